// File: doc/BRIEF.md
# Sub-Word Addressable General-Purpose Register File

This block stores sixteen 64-bit general-purpose registers. It has one write port and two independent read ports. Each port gives a register index, a two-bit operand size and a high-byte select, so a datapath can read or write a byte, a halfword, a word or the full doubleword of any register. The width of a write decides what happens to the rest of the register. A full-width write replaces every bit. A word write clears the upper half of the register. Byte and halfword writes merge into the old value and leave the other bits as they were.

The second byte (bits 15:8) of the first four registers can be reached as a byte of its own. A high-byte request on any other register is illegal. For the write port, an illegal request raises an error flag and the write is dropped. For a read port, it raises that port's error flag and the port returns zero. Read data always comes back right-aligned, with every bit above the operand width forced to zero.

A write commits on the rising clock edge. A read of the register being written in the same cycle already sees the merged result: the write-first forwarding path applies the same merge and clear rules as the storage update. A synchronous active-high reset clears all sixteen registers.

Top module: `subword_regfile`

## Requirements
- R1: One clock edge with `rst` high clears all sixteen registers, so a full-width read of any register afterwards returns zero.
- R2: A write with size code 2'b11 replaces all 64 bits of the target register with `wr_data`.
- R3: A write with size code 2'b10 puts `wr_data[31:0]` into bits 31:0 and sets bits 63:32 to zero.
- R4: A write with size code 2'b01 puts `wr_data[15:0]` into bits 15:0 and leaves bits 63:16 unchanged.
- R5: A write with size code 2'b00 and the high-byte select low puts `wr_data[7:0]` into bits 7:0 and leaves bits 63:8 unchanged. This works on every index, 0 to 15.
- R6: A write with size code 2'b00 and the high-byte select high, to index 0 to 3, puts `wr_data[7:0]` into bits 15:8 and leaves all other bits unchanged.
- R7: A size-2'b00 access with the high-byte select high to index 4 or above is illegal. On the write port it raises `wr_err` in that cycle and leaves the register unchanged. On a read port it raises that port's error flag and the port returns zero.
- R8: A read returns its field right-aligned and zero-padded: 8 bits for code 2'b00, 16 bits for 2'b01, 32 bits for 2'b10 and 64 bits for 2'b11. A legal high-byte read returns bits 15:8 in bits 7:0.
- R9: The high-byte select has no effect for size codes 2'b01, 2'b10 and 2'b11. It never raises an error and never moves the field.
- R10: A read of the register being written in the same cycle returns the merged value that the write will store. A suppressed write is not forwarded.
- R11: The two read ports work independently. Each one returns its own register, size and field in the same cycle.
- R12: In a cycle with `wr_en` low, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset of all registers |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 2 | Write size code (00 byte, 01 halfword, 10 word, 11 doubleword) |
| wr_hi | input | 1 | Write targets bits 15:8 (byte size only) |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Illegal high-byte write; the write is dropped |
| rd0_idx | input | 4 | Read port 0 register index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_data | output | 64 | Read port 0 data, right-aligned and zero-padded |
| rd0_err | output | 1 | Read port 0 illegal high-byte request |
| rd1_idx | input | 4 | Read port 1 register index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_data | output | 64 | Read port 1 data, right-aligned and zero-padded |
| rd1_err | output | 1 | Read port 1 illegal high-byte request |

## Verification
The checker watches, on every cycle, the properties that can be seen at the ports alone. It checks that read data is zero above the operand width, that an erroring read returns zero, and that the upper half reads back zero when a word write is forwarded. It also checks that a register held in view stays stable while no write occurs, that a rejected high-byte write leaves its target intact, and that reads are cleared after reset. Whether a byte or halfword merge keeps exactly the right neighbouring bits, and whether a high-byte write lands in bits 15:8, only shows when the bench's reference model compares against scenarios that first fill registers with known patterns and then read them back. The same holds for matching the forwarded value against the stored value under every size.

// File: rtl/subword_rf_pkg.sv
package subword_rf_pkg;

   typedef enum logic [1:0] {
      OPSZ_BYTE  = 2'b00,
      OPSZ_HALF  = 2'b01,
      OPSZ_WORD  = 2'b10,
      OPSZ_DWORD = 2'b11
   } opsz_e;

   localparam int BYTE_BITS = 8;
   localparam int HALF_BITS = 16;

endpackage

// File: rtl/subword_rf_wmerge.sv
module subword_rf_wmerge
   import subword_rf_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] wdata,
   input  logic [1:0]      size,
   input  logic            hi_sel,
   output logic [XLEN-1:0] merged
);
   localparam int HALF = XLEN / 2;

   opsz_e sz;
   assign sz = opsz_e'(size);

   always_comb begin
      merged = old_val;
      unique case (sz)
         OPSZ_BYTE: begin
            if (hi_sel) merged[2*BYTE_BITS-1:BYTE_BITS] = wdata[BYTE_BITS-1:0];
            else        merged[BYTE_BITS-1:0]           = wdata[BYTE_BITS-1:0];
         end
         OPSZ_HALF:  merged[HALF_BITS-1:0] = wdata[HALF_BITS-1:0];
         OPSZ_WORD:  merged = {{(XLEN-HALF){1'b0}}, wdata[HALF-1:0]};
         OPSZ_DWORD: merged = wdata;
         default:    merged = old_val;
      endcase
   end

endmodule

// File: rtl/subword_rf_rdfield.sv
module subword_rf_rdfield
   import subword_rf_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] src,
   input  logic [1:0]      size,
   input  logic            hi_sel,
   input  logic            illegal,
   output logic [XLEN-1:0] field
);
   localparam int HALF = XLEN / 2;

   opsz_e sz;
   assign sz = opsz_e'(size);

   always_comb begin
      field = '0;
      if (!illegal) begin
         unique case (sz)
            OPSZ_BYTE: begin
               if (hi_sel) field[BYTE_BITS-1:0] = src[2*BYTE_BITS-1:BYTE_BITS];
               else        field[BYTE_BITS-1:0] = src[BYTE_BITS-1:0];
            end
            OPSZ_HALF:  field[HALF_BITS-1:0] = src[HALF_BITS-1:0];
            OPSZ_WORD:  field[HALF-1:0]      = src[HALF-1:0];
            OPSZ_DWORD: field                = src;
            default:    field                = '0;
         endcase
      end
   end

endmodule

// File: rtl/subword_rf_bank.sv
module subword_rf_bank #(
   parameter int XLEN     = 64,
   parameter int NUM_REGS = 16,
   parameter int NPORT    = 3,
   localparam int IW      = $clog2(NUM_REGS)
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        we,
   input  logic [IW-1:0]               widx,
   input  logic [XLEN-1:0]             wval,
   input  logic [NPORT-1:0][IW-1:0]    ridx,
   output logic [NPORT-1:0][XLEN-1:0]  rval
);
   logic [XLEN-1:0] regs [NUM_REGS];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (we) begin
         regs[widx] <= wval;
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign rval[p] = regs[ridx[p]];
   end

endmodule

// File: rtl/subword_regfile.sv
module subword_regfile #(
   parameter int XLEN           = 64,
   parameter int NUM_REGS       = 16,
   parameter int HIGH_BYTE_REGS = 4,
   parameter bit BYPASS_EN      = 1'b1,
   localparam int IW            = $clog2(NUM_REGS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [IW-1:0]   wr_idx,
   input  logic [1:0]      wr_size,
   input  logic            wr_hi,
   input  logic [XLEN-1:0] wr_data,
   output logic            wr_err,
   input  logic [IW-1:0]   rd0_idx,
   input  logic [1:0]      rd0_size,
   input  logic            rd0_hi,
   output logic [XLEN-1:0] rd0_data,
   output logic            rd0_err,
   input  logic [IW-1:0]   rd1_idx,
   input  logic [1:0]      rd1_size,
   input  logic            rd1_hi,
   output logic [XLEN-1:0] rd1_data,
   output logic            rd1_err
);
   localparam int NUM_RD = 2;
   localparam int NPORT  = NUM_RD + 1;
   localparam int OLD_P  = NUM_RD;

   if (XLEN < 32 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("subword_regfile: XLEN must be even and at least 32");
   end
   if (NUM_REGS < 2 || NUM_REGS != (1 << IW)) begin : g_bad_regs
      $error("subword_regfile: NUM_REGS must be a power of two");
   end
   if (HIGH_BYTE_REGS > NUM_REGS) begin : g_bad_hb
      $error("subword_regfile: HIGH_BYTE_REGS exceeds NUM_REGS");
   end

   function automatic logic hb_illegal(input logic [IW-1:0] idx,
                                       input logic [1:0] sz, input logic hi);
      return (sz == 2'b00) && hi && (int'(idx) >= HIGH_BYTE_REGS);
   endfunction

   logic [NPORT-1:0][IW-1:0]   bank_idx;
   logic [NPORT-1:0][XLEN-1:0] bank_val;
   logic [NUM_RD-1:0][1:0]     rd_size_a;
   logic [NUM_RD-1:0]          rd_hi_a;
   logic [NUM_RD-1:0]          rd_err_a;
   logic [NUM_RD-1:0][XLEN-1:0] rd_data_a;
   logic [XLEN-1:0]            merged;
   logic                       wr_commit;

   assign bank_idx[0]     = rd0_idx;
   assign bank_idx[1]     = rd1_idx;
   assign bank_idx[OLD_P] = wr_idx;
   assign rd_size_a[0]    = rd0_size;
   assign rd_size_a[1]    = rd1_size;
   assign rd_hi_a[0]      = rd0_hi;
   assign rd_hi_a[1]      = rd1_hi;

   assign wr_err    = wr_en && hb_illegal(wr_idx, wr_size, wr_hi);
   assign wr_commit = wr_en && !wr_err;

   subword_rf_bank #(
      .XLEN     (XLEN),
      .NUM_REGS (NUM_REGS),
      .NPORT    (NPORT)
   ) u_bank (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_commit),
      .widx (wr_idx),
      .wval (merged),
      .ridx (bank_idx),
      .rval (bank_val)
   );

   subword_rf_wmerge #(.XLEN(XLEN)) u_wmerge (
      .old_val (bank_val[OLD_P]),
      .wdata   (wr_data),
      .size    (wr_size),
      .hi_sel  (wr_hi),
      .merged  (merged)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [XLEN-1:0] src;
      if (BYPASS_EN) begin : g_fwd
         assign src = (wr_commit && (wr_idx == bank_idx[p])) ? merged : bank_val[p];
      end else begin : g_nofwd
         assign src = bank_val[p];
      end
      assign rd_err_a[p] = hb_illegal(bank_idx[p], rd_size_a[p], rd_hi_a[p]);
      subword_rf_rdfield #(.XLEN(XLEN)) u_field (
         .src     (src),
         .size    (rd_size_a[p]),
         .hi_sel  (rd_hi_a[p]),
         .illegal (rd_err_a[p]),
         .field   (rd_data_a[p])
      );
   end

   assign rd0_data = rd_data_a[0];
   assign rd1_data = rd_data_a[1];
   assign rd0_err  = rd_err_a[0];
   assign rd1_err  = rd_err_a[1];

endmodule

// File: rtl/subword_rf_chk.sv
module subword_rf_chk #(
   parameter int XLEN      = 64,
   parameter int IW        = 4,
   parameter bit BYPASS_EN = 1'b1
) (
   input logic            clk,
   input logic            rst,
   input logic            wr_en,
   input logic [IW-1:0]   wr_idx,
   input logic [1:0]      wr_size,
   input logic            wr_err,
   input logic [IW-1:0]   rd0_idx,
   input logic [1:0]      rd0_size,
   input logic [XLEN-1:0] rd0_data,
   input logic            rd0_err,
   input logic [1:0]      rd1_size,
   input logic [XLEN-1:0] rd1_data
);
   localparam int HALF = XLEN / 2;

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !wr_en) |-> (rd0_data == '0)); // R1

   AST_WORD_FWD_ZEXT: assert property (@(posedge clk) disable iff (rst)
      (BYPASS_EN && wr_en && !wr_err && wr_size == 2'b10 &&
       rd0_idx == wr_idx && rd0_size == 2'b11) |-> (rd0_data[XLEN-1:HALF] == '0)); // R3

   AST_ERR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
      ($past(wr_err) && !$past(rd0_err) && !wr_en &&
       $past(rd0_idx) == $past(wr_idx) && $past(rd0_size) == 2'b11 &&
       rd0_idx == $past(rd0_idx) && rd0_size == 2'b11) |-> $stable(rd0_data)); // R7

   AST_ERR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      rd0_err |-> (rd0_data == '0)); // R7

   AST_PAD_BYTE: assert property (@(posedge clk) disable iff (rst)
      (rd0_size == 2'b00) |-> (rd0_data[XLEN-1:8] == '0)); // R8

   AST_PAD_HALF: assert property (@(posedge clk) disable iff (rst)
      (rd0_size == 2'b01) |-> (rd0_data[XLEN-1:16] == '0)); // R8

   AST_PAD_WORD_P1: assert property (@(posedge clk) disable iff (rst)
      (rd1_size == 2'b10) |-> (rd1_data[XLEN-1:HALF] == '0)); // R11

   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      (!wr_en && !$past(wr_en) && !$past(rst) && rd0_idx == $past(rd0_idx) &&
       rd0_size == $past(rd0_size) && !rd0_err && !$past(rd0_err) &&
       rd0_size != 2'b00) |-> $stable(rd0_data)); // R12

endmodule

bind subword_regfile subword_rf_chk #(
   .XLEN      (XLEN),
   .IW        (IW),
   .BYPASS_EN (BYPASS_EN)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_size  (wr_size),
   .wr_err   (wr_err),
   .rd0_idx  (rd0_idx),
   .rd0_size (rd0_size),
   .rd0_data (rd0_data),
   .rd0_err  (rd0_err),
   .rd1_size (rd1_size),
   .rd1_data (rd1_data)
);

// File: tb/subword_regfile_tb_top.sv
module subword_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [1:0]  wr_size = '0;
   logic        wr_hi = 1'b0;
   logic [63:0] wr_data = '0;
   logic        wr_err;
   logic [3:0]  rd0_idx = '0;
   logic [1:0]  rd0_size = 2'b11;
   logic        rd0_hi = 1'b0;
   logic [63:0] rd0_data;
   logic        rd0_err;
   logic [3:0]  rd1_idx = '0;
   logic [1:0]  rd1_size = 2'b11;
   logic        rd1_hi = 1'b0;
   logic [63:0] rd1_data;
   logic        rd1_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [63:0] model [16];

   always #10 clk = ~clk;

   subword_regfile dut_i (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
      .wr_data(wr_data), .wr_err(wr_err),
      .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi),
      .rd0_data(rd0_data), .rd0_err(rd0_err),
      .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi),
      .rd1_data(rd1_data), .rd1_err(rd1_err)
   );

   function automatic logic [63:0] width_mask(input logic [1:0] s);
      return (s == 2'b11) ? {64{1'b1}} : ((64'd1 << (8 << s)) - 64'd1);
   endfunction

   function automatic bit bad_hb(input logic [3:0] i, input logic [1:0] s, input logic h);
      return (s == 2'b00) && h && (i > 4'd3);
   endfunction

   function automatic logic [63:0] model_write(input logic [63:0] old, input logic [63:0] d,
                                               input logic [1:0] s, input logic h);
      int sh = (s == 2'b00 && h) ? 8 : 0;
      if (s == 2'b10) return d & width_mask(2'b10);
      return (old & ~(width_mask(s) << sh)) | ((d & width_mask(s)) << sh);
   endfunction

   function automatic logic [63:0] model_read(input logic [63:0] v, input logic [3:0] i,
                                              input logic [1:0] s, input logic h);
      int sh = (s == 2'b00 && h) ? 8 : 0;
      if (bad_hb(i, s, h)) return 64'd0;
      return (v >> sh) & width_mask(s);
   endfunction

   function automatic logic [63:0] seen_value(input logic [3:0] ri);
      if (wr_en && !bad_hb(wr_idx, wr_size, wr_hi) && wr_idx == ri)
         return model_write(model[ri], wr_data, wr_size, wr_hi);
      return model[ri];
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag,
                       input logic we, input logic [3:0] wi, input logic [1:0] ws,
                       input logic wh, input logic [63:0] wd,
                       input logic [3:0] r0i, input logic [1:0] r0s, input logic r0h,
                       input logic [3:0] r1i, input logic [1:0] r1s, input logic r1h);
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_size = ws; wr_hi = wh; wr_data = wd;
      rd0_idx = r0i; rd0_size = r0s; rd0_hi = r0h;
      rd1_idx = r1i; rd1_size = r1s; rd1_hi = r1h;
      #5;
      check(tag, "rd0_data", rd0_data, model_read(seen_value(r0i), r0i, r0s, r0h));
      check(tag, "rd1_data", rd1_data, model_read(seen_value(r1i), r1i, r1s, r1h));
      check(tag, "rd0_err", {63'd0, rd0_err}, {63'd0, bad_hb(r0i, r0s, r0h)});
      check(tag, "rd1_err", {63'd0, rd1_err}, {63'd0, bad_hb(r1i, r1s, r1h)});
      check(tag, "wr_err", {63'd0, wr_err}, {63'd0, we && bad_hb(wi, ws, wh)});
      @(posedge clk);
      #1;
      if (we && !bad_hb(wi, ws, wh)) model[wi] = model_write(model[wi], wd, ws, wh);
   endtask

   task automatic rd2(input string tag, input logic [3:0] a, input logic [1:0] sa, input logic ha,
                      input logic [3:0] b, input logic [1:0] sb, input logic hb);
      step(tag, 1'b0, 4'd0, 2'b11, 1'b0, 64'd0, a, sa, ha, b, sb, hb);
   endtask

   task automatic wr(input string tag, input logic [3:0] i, input logic [1:0] s,
                     input logic h, input logic [63:0] d);
      step(tag, 1'b1, i, s, h, d, i, 2'b11, 1'b0, i, 2'b11, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) model[i] = 64'hDEAD_BEEF_DEAD_BEEF;
      repeat (2) @(posedge clk);
      #1;
      for (int i = 0; i < 16; i++) model[i] = '0;
      @(negedge clk);
      rst = 1'b0;

      // R1: every register reads zero after reset
      for (int i = 0; i < 16; i += 2) rd2("R1", 4'(i), 2'b11, 1'b0, 4'(i + 1), 2'b11, 1'b0);

      // R2: full write
      wr("R2", 4'd5, 2'b11, 1'b0, 64'hA5A5_5A5A_0123_4567);
      rd2("R2", 4'd5, 2'b11, 1'b0, 4'd5, 2'b11, 1'b1);
      // R3: word write clears the upper half
      wr("R3", 4'd5, 2'b10, 1'b0, 64'h1234_5678_9ABC_DEF0);
      rd2("R3", 4'd5, 2'b11, 1'b0, 4'd5, 2'b10, 1'b0);
      // R4: halfword merge
      wr("R4", 4'd7, 2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      wr("R4", 4'd7, 2'b01, 1'b0, 64'h1111_2222_3333_BEEF);
      rd2("R4", 4'd7, 2'b11, 1'b0, 4'd7, 2'b01, 1'b0);
      // R5: low byte merge on a new-range index
      wr("R5", 4'd9, 2'b11, 1'b0, 64'h0102_0304_0506_0708);
      wr("R5", 4'd9, 2'b00, 1'b0, 64'hFFFF_FFFF_FFFF_FF99);
      rd2("R5", 4'd9, 2'b11, 1'b0, 4'd9, 2'b00, 1'b0);
      // R6: high byte write to index 2
      wr("R6", 4'd2, 2'b11, 1'b0, 64'hCAFE_F00D_8877_6655);
      wr("R6", 4'd2, 2'b00, 1'b1, 64'h0000_0000_0000_00C3);
      rd2("R6", 4'd2, 2'b11, 1'b0, 4'd3, 2'b11, 1'b0);
      // R8: high byte read returns bits 15:8 in the low byte
      rd2("R8", 4'd2, 2'b00, 1'b1, 4'd2, 2'b00, 1'b0);
      rd2("R8", 4'd5, 2'b01, 1'b0, 4'd9, 2'b10, 1'b0);
      // R7: illegal high byte write and read
      wr("R7", 4'd6, 2'b11, 1'b0, 64'h7766_5544_3322_1100);
      step("R7", 1'b1, 4'd6, 2'b00, 1'b1, 64'hEE, 4'd6, 2'b11, 1'b0, 4'd12, 2'b00, 1'b1);
      rd2("R7", 4'd6, 2'b11, 1'b0, 4'd4, 2'b00, 1'b1);
      // R9: high select ignored for halfword, word and doubleword
      step("R9", 1'b1, 4'd12, 2'b01, 1'b1, 64'h0000_0000_0000_ABCD, 4'd12, 2'b11, 1'b1, 4'd12, 2'b10, 1'b1);
      rd2("R9", 4'd12, 2'b11, 1'b1, 4'd12, 2'b01, 1'b1);
      // R10: forwarding with each size
      step("R10", 1'b1, 4'd1, 2'b11, 1'b0, 64'h1357_9BDF_2468_ACE0, 4'd1, 2'b11, 1'b0, 4'd1, 2'b00, 1'b1);
      step("R10", 1'b1, 4'd1, 2'b00, 1'b1, 64'h55, 4'd1, 2'b11, 1'b0, 4'd1, 2'b01, 1'b0);
      step("R10", 1'b1, 4'd1, 2'b10, 1'b0, 64'hFFFF_0000_4444_3333, 4'd1, 2'b11, 1'b0, 4'd0, 2'b11, 1'b0);
      step("R10", 1'b1, 4'd14, 2'b01, 1'b0, 64'h7777, 4'd14, 2'b11, 1'b0, 4'd14, 2'b00, 1'b0);
      // R11: independent ports with different sizes
      rd2("R11", 4'd2, 2'b10, 1'b0, 4'd7, 2'b00, 1'b0);
      // R12: idle cycles change nothing
      for (int k = 0; k < 4; k++) rd2("R12", 4'(k), 2'b11, 1'b0, 4'(k + 5), 2'b11, 1'b0);

      // R11: random mix of all sizes, selects, indices and collisions
      for (int n = 0; n < 400; n++) begin
         step("R11", 1'($urandom), 4'($urandom), 2'($urandom), 1'($urandom),
              {$urandom, $urandom},
              4'($urandom), 2'($urandom), 1'($urandom),
              4'($urandom), 2'($urandom), 1'($urandom));
      end
      for (int i = 0; i < 16; i += 2) rd2("R12", 4'(i), 2'b11, 1'b0, 4'(i + 1), 2'b11, 1'b0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule